// File: doc/BRIEF.md
# Four-Channel H-Bridge Gate Controller

This block turns a control byte and a set of per-channel duty values into switch-level gate signals for four H-bridges. Each bridge has two legs (A and B), and each leg has a high-side and a low-side switch. The control byte carries one enable bit and one direction bit per channel. Each channel's enable is also modulated by a pulse-width timer. The timer is shared, and each channel compares it against its own duty value, so the speed of each motor can be set on its own.

Most channels derive leg B from the inverse of the direction bit. A motor on one of those channels can only run forward, run in reverse or coast. Channels selected by the `BRAKE_MASK` parameter take leg B's level from a separate input instead. When both levels are equal, the two motor terminals are tied to the same rail and the motor brakes. Direction changes are held back until the timer wraps. The bridge then stays fully off for one tick as dead time. A fault output flags any leg whose two switches are commanded on together.

Top module: `hbridge_quad`

## Requirements
- R1: A control write stores `ctrl_data_i`. Bit c (c = 0..3) is the enable of channel c and bit 4+c is its direction bit. The enable takes effect on the first cycle after the write edge.
- R2: A channel whose stored enable bit is 0 has all four of its gate outputs at 0 (coast).
- R3: For every leg, the high and low gate outputs are never both 1.
- R4: On an inverter-type channel that is driving, direction 1 turns on leg A high and leg B low. Direction 0 turns on leg A low and leg B high. For channel c, leg A is gate index 2c and leg B is gate index 2c+1.
- R5: On a brake-capable channel (default: channel 3), leg B follows `dir_b_i[c]` instead of the inverse of the direction bit. Equal levels turn on both high or both low switches (brake). On inverter-type channels `dir_b_i` is ignored.
- R6: The PWM counter resets to 0 and counts up by one each clock, wrapping at 2^PWM_W. A channel drives only while counter < duty.
- R7: Duties reset to 0, and a duty of 0 never drives. A duty of 255 drives for 255 of the 256 ticks in each period. A duty write goes to the channel chosen by `duty_sel_i`.
- R8: A change in a channel's requested leg levels takes effect only when the counter goes from 255 to 0. During the counter-0 tick that follows a change, all four gates of that channel are 0.
- R9: If the requested levels did not change, the channel keeps driving through the counter-0 tick with no dead time.
- R10: `fault_o` is 1 exactly when some leg has both gates at 1. It therefore stays 0 under any sequence of writes.
- R11: During and after reset, with no writes, all gate outputs and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control byte write strobe |
| ctrl_data_i | input | 2*N_CH (8) | Enables [3:0], directions [7:4] |
| duty_wr_i | input | 1 | Duty write strobe |
| duty_sel_i | input | SEL_W (2) | Channel chosen by a duty write |
| duty_data_i | input | PWM_W (8) | Duty value |
| dir_b_i | input | N_CH (4) | Independent leg-B level for brake-capable channels |
| gate_hi_o | output | 2*N_CH (8) | High-side gates, index 2c = leg A, 2c+1 = leg B |
| gate_lo_o | output | 2*N_CH (8) | Low-side gates, same indexing |
| fault_o | output | 1 | Shoot-through detected on some leg |

## Verification
Some properties are checked on every cycle. Leg exclusivity, the absence of a fault, and the single-step advance of the PWM counter are among them. A coast must follow one cycle after a disabling write. A channel driving forward must never switch straight to reverse without an off tick in between. The bench scenarios cover what a single-cycle property cannot see: the exact leg pattern for each direction and brake setting, and the duty comparison at its edge value. They also show the on-tick count over a full period, and that a direction change waits for the wrap and then applies exactly one dead tick.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_drv_t;

  // on=0 -> both off; otherwise level picks which switch conducts
  function automatic leg_drv_t leg_drive(input logic on, input logic level);
    leg_drv_t d;
    d.hi = on & level;
    d.lo = on & ~level;
    return d;
  endfunction
endpackage

// File: rtl/hb_pwm_cnt.sv
module hb_pwm_cnt #(
  parameter int unsigned PWM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PWM_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [PWM_W-1:0] CNT_MAX = '1;

  logic [PWM_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/hb_chan.sv
module hb_chan
  import hb_pkg::*;
#(
  parameter int unsigned PWM_W = 8,
  parameter bit          BRAKE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             duty_we_i,
  input  logic [PWM_W-1:0] duty_d_i,
  input  logic             en_i,
  input  logic             req_a_i,
  input  logic             req_b_i,
  input  logic [PWM_W-1:0] cnt_i,
  input  logic             wrap_i,
  output leg_drv_t         leg_a_o,
  output leg_drv_t         leg_b_o
);
  // reset levels match a cleared control byte: inverter channel has b = ~a
  localparam logic [1:0] LVL_RST = {~BRAKE, 1'b0};

  logic [PWM_W-1:0] duty_q;
  logic [1:0]       lvl_q;
  logic             dead_q;
  logic [1:0]       lvl_req;
  logic             swap;
  logic             on;

  assign lvl_req = {req_b_i, req_a_i};
  assign swap    = wrap_i && (lvl_req != lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      lvl_q  <= LVL_RST;
      dead_q <= 1'b0;
    end else begin
      if (duty_we_i) duty_q <= duty_d_i;
      if (swap)      lvl_q  <= lvl_req;
      dead_q <= swap;
    end
  end

  assign on      = en_i && (cnt_i < duty_q) && !dead_q;
  assign leg_a_o = leg_drive(on, lvl_q[0]);
  assign leg_b_o = leg_drive(on, lvl_q[1]);
endmodule

// File: rtl/hb_overlap_det.sv
module hb_overlap_det #(
  parameter int unsigned N_LEG = 8
) (
  input  logic [N_LEG-1:0] hi_i,
  input  logic [N_LEG-1:0] lo_i,
  output logic             fault_o
);
  assign fault_o = |(hi_i & lo_i);
endmodule

// File: rtl/hbridge_quad.sv
module hbridge_quad
  import hb_pkg::*;
#(
  parameter int unsigned N_CH       = 4,
  parameter int unsigned PWM_W      = 8,
  parameter logic [N_CH-1:0] BRAKE_MASK = 4'b1000,
  localparam int unsigned SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned N_LEG = 2 * N_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [N_LEG-1:0] ctrl_data_i,
  input  logic             duty_wr_i,
  input  logic [SEL_W-1:0] duty_sel_i,
  input  logic [PWM_W-1:0] duty_data_i,
  input  logic [N_CH-1:0]  dir_b_i,
  output logic [N_LEG-1:0] gate_hi_o,
  output logic [N_LEG-1:0] gate_lo_o,
  output logic             fault_o
);
  logic [N_LEG-1:0] ctrl_q;
  logic [PWM_W-1:0] pwm_cnt;
  logic             pwm_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_data_i;
  end

  hb_pwm_cnt #(.PWM_W(PWM_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (pwm_cnt),
    .wrap_o (pwm_wrap)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    leg_drv_t leg_a, leg_b;
    logic     dir_a, dir_b, duty_we;

    assign dir_a   = ctrl_q[N_CH + c];
    assign dir_b   = BRAKE_MASK[c] ? dir_b_i[c] : ~dir_a;
    assign duty_we = duty_wr_i && (duty_sel_i == SEL_W'(c));

    hb_chan #(.PWM_W(PWM_W), .BRAKE(BRAKE_MASK[c])) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .duty_we_i (duty_we),
      .duty_d_i  (duty_data_i),
      .en_i      (ctrl_q[c]),
      .req_a_i   (dir_a),
      .req_b_i   (dir_b),
      .cnt_i     (pwm_cnt),
      .wrap_i    (pwm_wrap),
      .leg_a_o   (leg_a),
      .leg_b_o   (leg_b)
    );

    assign gate_hi_o[2*c]   = leg_a.hi;
    assign gate_lo_o[2*c]   = leg_a.lo;
    assign gate_hi_o[2*c+1] = leg_b.hi;
    assign gate_lo_o[2*c+1] = leg_b.lo;
  end

  hb_overlap_det #(.N_LEG(N_LEG)) u_det (
    .hi_i    (gate_hi_o),
    .lo_i    (gate_lo_o),
    .fault_o (fault_o)
  );
endmodule

// File: rtl/hbridge_quad_chk.sv
module hbridge_quad_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned PWM_W = 8,
  localparam int unsigned N_LEG = 2 * N_CH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_wr_i,
  input logic [N_LEG-1:0] ctrl_data_i,
  input logic [N_LEG-1:0] gate_hi_o,
  input logic [N_LEG-1:0] gate_lo_o,
  input logic             fault_o,
  input logic [PWM_W-1:0] cnt_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_leg_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_o & gate_lo_o) == '0);

  p_no_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o);

  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> cnt_i == PWM_W'($past(cnt_i) + 1'b1));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    p_coast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr_i && !ctrl_data_i[c]) |=>
        (gate_hi_o[2*c +: 2] == 2'b00 && gate_lo_o[2*c +: 2] == 2'b00));

    // forward (A high, B low) never flips straight to reverse
    p_dead_time_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(gate_hi_o[2*c]) && $past(gate_lo_o[2*c+1])) |->
        !(gate_lo_o[2*c] && gate_hi_o[2*c+1]));
  end
endmodule

bind hbridge_quad hbridge_quad_chk #(.N_CH(N_CH), .PWM_W(PWM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_wr_i   (ctrl_wr_i),
  .ctrl_data_i (ctrl_data_i),
  .gate_hi_o   (gate_hi_o),
  .gate_lo_o   (gate_lo_o),
  .fault_o     (fault_o),
  .cnt_i       (pwm_cnt)
);

// File: tb/tb_hbridge_quad.sv
module tb_hbridge_quad;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 6;

  // {ctrl[8], dir_b[4], duty {d3,d2,d1,d0}[32], exp_hi[8], exp_lo[8]}
  localparam logic [59:0] VECS [0:N_VEC-1] = '{
    {8'h00, 4'h0, 32'hFFFFFFFF, 8'h00, 8'h00},
    {8'h0F, 4'h0, 32'hFFFFFFFF, 8'h2A, 8'hD5},
    {8'hFF, 4'h8, 32'hFFFFFFFF, 8'hD5, 8'h2A},
    {8'hA5, 4'h7, 32'hFFFFFFFF, 8'h22, 8'h11},
    {8'h0F, 4'h0, 32'hFF0B0A00, 8'h20, 8'hD0},
    {8'h88, 4'h0, 32'hFFFFFFFF, 8'h40, 8'h80}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_wr_i = 1'b0;
  logic [7:0] ctrl_data_i = '0;
  logic       duty_wr_i = 1'b0;
  logic [1:0] duty_sel_i = '0;
  logic [7:0] duty_data_i = '0;
  logic [3:0] dir_b_i = '0;
  logic [7:0] gate_hi_o, gate_lo_o;
  logic       fault_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_cnt;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hbridge_quad dut (
    .clk_i, .rst_ni, .ctrl_wr_i, .ctrl_data_i, .duty_wr_i, .duty_sel_i,
    .duty_data_i, .dir_b_i, .gate_hi_o, .gate_lo_o, .fault_o
  );

  // independent model of the free-running timer
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_cnt <= '0;
    else         m_cnt <= m_cnt + 8'd1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk_i);
    ctrl_wr_i = 1'b1; ctrl_data_i = v;
    @(negedge clk_i);
    ctrl_wr_i = 1'b0;
  endtask

  task automatic wr_duty(input int ch, input logic [7:0] v);
    @(negedge clk_i);
    duty_wr_i = 1'b1; duty_sel_i = 2'(ch); duty_data_i = v;
    @(negedge clk_i);
    duty_wr_i = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    do @(negedge clk_i); while (m_cnt != v);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk_i);
    check("R11 hi in reset", 32'(gate_hi_o), 32'h0);
    check("R11 lo in reset", 32'(gate_lo_o), 32'h0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check("R11 hi after reset", 32'(gate_hi_o), 32'h0);
    check("R11 fault after reset", 32'(fault_o), 32'h0);

    // table: R1 R2 R4 R5 R6 patterns, sampled at counter 10
    for (int i = 0; i < N_VEC; i++) begin
      logic [59:0] v;
      v = VECS[i];
      for (int c = 0; c < 4; c++) wr_duty(c, v[16 + 8*c +: 8]);
      dir_b_i = v[51:48];
      wr_ctrl(v[59:52]);
      repeat (300) @(negedge clk_i);
      wait_cnt(8'd10);
      check($sformatf("R1 R2 R4 R5 R6 vec%0d hi", i), 32'(gate_hi_o), 32'(v[15:8]));
      check($sformatf("R1 R2 R4 R5 R6 vec%0d lo", i), 32'(gate_lo_o), 32'(v[7:0]));
      check($sformatf("R10 vec%0d fault", i), 32'(fault_o), 32'h0);
    end

    // R1: enable cleared takes effect the next cycle
    dir_b_i = 4'h0;
    wr_ctrl(8'h0F);
    for (int c = 0; c < 4; c++) wr_duty(c, 8'hFF);
    repeat (300) @(negedge clk_i);
    wait_cnt(8'd20);
    wr_ctrl(8'h00);
    check("R1 R2 disable next cycle hi", 32'(gate_hi_o), 32'h0);
    check("R1 R2 disable next cycle lo", 32'(gate_lo_o), 32'h0);

    // R7: on-tick counts per period
    for (int k = 0; k < 3; k++) begin
      logic [7:0] d;
      int on_cnt;
      d = (k == 0) ? 8'd0 : (k == 1) ? 8'd128 : 8'd255;
      wr_duty(0, d);
      wr_ctrl(8'h01);
      repeat (300) @(negedge clk_i);
      on_cnt = 0;
      for (int t = 0; t < 256; t++) begin
        @(negedge clk_i);
        if ((gate_hi_o[1:0] | gate_lo_o[1:0]) != 2'b00) on_cnt++;
      end
      check($sformatf("R7 duty %0d on ticks", d), 32'(on_cnt), 32'(d));
    end

    // R8: direction change waits for wrap, one dead tick; R9: no dead tick when steady
    wr_ctrl(8'h01);
    wr_duty(0, 8'hFF);
    repeat (300) @(negedge clk_i);
    wait_cnt(8'd100);
    ctrl_wr_i = 1'b1; ctrl_data_i = 8'h11;
    @(negedge clk_i);
    ctrl_wr_i = 1'b0;
    check("R8 held before wrap hi", 32'(gate_hi_o), 32'h02);
    wait_cnt(8'd254);
    check("R8 held at 254 hi", 32'(gate_hi_o), 32'h02);
    check("R8 held at 254 lo", 32'(gate_lo_o), 32'h01);
    wait_cnt(8'd0);
    check("R8 dead tick hi", 32'(gate_hi_o), 32'h00);
    check("R8 dead tick lo", 32'(gate_lo_o), 32'h00);
    wait_cnt(8'd1);
    check("R8 new direction hi", 32'(gate_hi_o), 32'h01);
    check("R8 new direction lo", 32'(gate_lo_o), 32'h02);
    wait_cnt(8'd0);
    check("R9 steady wrap hi", 32'(gate_hi_o), 32'h01);
    check("R9 steady wrap lo", 32'(gate_lo_o), 32'h02);

    // R3 R10: random register traffic
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk_i);
      if ((gate_hi_o & gate_lo_o) != 8'h00) begin
        check("R3 leg overlap", 32'(gate_hi_o & gate_lo_o), 32'h0);
      end
      if (fault_o !== 1'b0) check("R10 fault", 32'(fault_o), 32'h0);
      ctrl_wr_i   = ($urandom_range(0, 3) == 0);
      ctrl_data_i = 8'($urandom);
      duty_wr_i   = ($urandom_range(0, 3) == 0);
      duty_sel_i  = 2'($urandom);
      duty_data_i = 8'($urandom);
      dir_b_i     = 4'($urandom);
    end
    ctrl_wr_i = 1'b0; duty_wr_i = 1'b0;
    check("R3 R10 random run fault", 32'(fault_o), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule